// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a set of machine-check reporting banks and decides, for each incoming error report, whether the report is logged, dropped, refused, or escalated to a system reset. Every bank holds a control word, a status word, an address word and a miscellaneous word. All banks share a capability word, a global status word and a global control word. A report arrives as a one-cycle strobe that carries the target bank, the bank status, the global status, the address, the misc word, an "unconditional" flag and a "broadcast" flag.

The outcome appears one cycle after the strobe as a result code. A logged uncorrected error also pulses a machine-check interrupt, and an escalated error pulses a reset request. Corrected and uncorrected errors follow different rules. Action-optional reports are suppressed while a machine check is in progress. An entry that already holds a valid error is marked as overflowed when it is written again. Software reads and writes every register through a simple word-addressed bus, and reads return data one cycle later.

Top module: `mcb_logger`

## Requirements
- R1: After reset the capability word is 0x100 plus NUM_BANKS, the global control word and every bank control word are all ones, and the global status and all bank status, address and misc words are zero. No result, interrupt or reset request is pending.
- R2: Register words are addressed as follows: capability at 0, global status at 1, global control at 2, and bank b field f at 8+4b+f, where f is 0 control, 1 status, 2 address and 3 misc. A write takes effect at the next edge. Read data appears on the cycle after the read strobe. An unmapped address reads as zero.
- R3: A report is rejected (code 2) when the capability word is zero, when the bank index is not below capability bits [7:0], when the bank index is not below NUM_BANKS, or when status bit 63 (valid) is clear. A rejected report changes no register.
- R4: A report with the broadcast flag set is rejected unless the processor family is above 6, or the family is 6 and the model is 14 or higher. The model is the extended-model nibble times 16 plus the base-model nibble.
- R5: A report whose status bit 55 (action required) is clear and whose unconditional flag is clear is dropped (code 1) while global status bit 2 (in progress) is set. The bank is left unchanged.
- R6: An uncorrected report (status bit 61) is dropped (code 1) when capability bit 8 is set and the global control word is not all ones, or when the bank control word is not all ones.
- R7: An uncorrected report that passes R6 while global status bit 2 is set, or while the mce_en input is low, gives code 3 and a one-cycle reset_req pulse, and writes nothing.
- R8: An accepted uncorrected report (code 0) writes the bank status, address and misc words and replaces the global status with the injected one. It sets status bit 62 (overflow) if the old entry was valid, and pulses mc_irq for one cycle.
- R9: A corrected report (code 0) overwrites the bank's status, address and misc words when the old entry is invalid or is not uncorrected. It adds bit 62 if the old entry was valid. The global status is not changed and no interrupt is raised.
- R10: A corrected report aimed at a valid uncorrected entry gives code 1. It only sets bit 62 of that entry and leaves its other bits, its address and its misc word unchanged.
- R11: res_valid is high for exactly the one cycle that follows each inject strobe. An injection overrides a bus write to the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_en | input | 1 | Machine-check enable from the processor control state |
| ver_family | input | 4 | Processor family nibble |
| ver_model | input | 4 | Base model nibble |
| ver_ext_model | input | 4 | Extended model nibble |
| inj_valid | input | 1 | Report strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status to log |
| inj_gstat | input | 64 | Global status to log with an uncorrected error |
| inj_addr | input | 64 | Error address word |
| inj_misc | input | 64 | Error misc word |
| inj_uncond | input | 1 | Deliver action-optional report even while in progress |
| inj_bcast | input | 1 | Report is a broadcast |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe |
| reg_addr | input | ADDR_W | Bus word address |
| reg_wdata | input | 64 | Bus write data |
| reg_rdata | output | 64 | Bus read data, registered |
| res_valid | output | 1 | Result code valid |
| res_code | output | 2 | 0 accepted, 1 dropped, 2 rejected, 3 reset |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
A corrupted bank status bit is visible on the next report to that bank: the valid or uncorrected bit chooses between overwrite and overflow-only, so the result code and the read-back status diverge within two cycles. A wrong in-progress bit in the global status turns action-optional reports into drops and uncorrected reports into reset requests. This shows on the very next result code. Control words that are not all ones show up as unexpected drops, so each is written to a non-ones value and then probed with an uncorrected report.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int WORD_W   = 64;
  localparam int ST_VAL   = 63;
  localparam int ST_OVER  = 62;
  localparam int ST_UC    = 61;
  localparam int ST_AR    = 55;
  localparam int GS_MCIP  = 2;
  localparam int CAP_GCTL = 8;
  localparam int BANK_BASE = 8;

  typedef enum logic [1:0] {
    RES_ACCEPT = 2'd0,
    RES_DROP   = 2'd1,
    RES_REJECT = 2'd2,
    RES_RESET  = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_FULL = 2'd1,
    UPD_OVER = 2'd2
  } upd_e;

  typedef struct packed {
    logic [7:0]        bank;
    logic [WORD_W-1:0] status;
    logic [WORD_W-1:0] gstat;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] misc;
    logic              uncond;
    logic              bcast;
  } inj_t;
endpackage

// File: rtl/mcb_bcast_check.sv
module mcb_bcast_check (
  input  logic [3:0] family,
  input  logic [3:0] model,
  input  logic [3:0] ext_model,
  output logic       ok
);
  logic [7:0] full_model;

  always_comb begin
    full_model = {ext_model, 4'b0000} + {4'b0000, model};
    ok = (family > 4'd6) || ((family == 4'd6) && (full_model >= 8'd14));
  end
endmodule

// File: rtl/mcb_decide.sv
module mcb_decide
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  inj_t              inj,
  input  logic [7:0]        cap_banks,
  input  logic              cap_zero,
  input  logic              cap_gctl,
  input  logic              gs_mcip,
  input  logic [WORD_W-1:0] gctl,
  input  logic [WORD_W-1:0] bank_ctl,
  input  logic [WORD_W-1:0] bank_status,
  input  logic              mce_en,
  input  logic              bcast_ok,
  output res_e              code,
  output upd_e              upd,
  output logic [WORD_W-1:0] new_status,
  output logic              wr_gstat,
  output logic              irq,
  output logic              rreq
);
  localparam logic [7:0] NB8 = 8'(NUM_BANKS);

  logic old_val, old_uc, bad_index;

  always_comb begin
    old_val    = bank_status[ST_VAL];
    old_uc     = bank_status[ST_UC];
    bad_index  = (inj.bank >= cap_banks) || (inj.bank >= NB8);
    code       = RES_ACCEPT;
    upd        = UPD_NONE;
    new_status = inj.status;
    wr_gstat   = 1'b0;
    irq        = 1'b0;
    rreq       = 1'b0;
    if (cap_zero || bad_index || !inj.status[ST_VAL] || (inj.bcast && !bcast_ok)) begin
      code = RES_REJECT;
    end else if (!inj.uncond && !inj.status[ST_AR] && gs_mcip) begin
      code = RES_DROP;
    end else if (inj.status[ST_UC]) begin
      if ((cap_gctl && (gctl != '1)) || (bank_ctl != '1)) begin
        code = RES_DROP;
      end else if (gs_mcip || !mce_en) begin
        code = RES_RESET;
        rreq = 1'b1;
      end else begin
        upd      = UPD_FULL;
        wr_gstat = 1'b1;
        irq      = 1'b1;
        new_status[ST_OVER] = inj.status[ST_OVER] | old_val;
      end
    end else if (!old_val || !old_uc) begin
      upd = UPD_FULL;
      new_status[ST_OVER] = inj.status[ST_OVER] | old_val;
    end else begin
      code       = RES_DROP;
      upd        = UPD_OVER;
      new_status = bank_status;
      new_status[ST_OVER] = 1'b1;
    end
  end
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [1:0]        bus_field,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              inj_we,
  input  logic              inj_over_only,
  input  logic [WORD_W-1:0] inj_status,
  input  logic [WORD_W-1:0] inj_addr,
  input  logic [WORD_W-1:0] inj_misc,
  output logic [WORD_W-1:0] ctl_q,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] misc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '1;
      status_q <= '0;
      addr_q   <= '0;
      misc_q   <= '0;
    end else begin
      if (bus_we) begin
        case (bus_field)
          2'd0: ctl_q    <= bus_wdata;
          2'd1: status_q <= bus_wdata;
          2'd2: addr_q   <= bus_wdata;
          default: misc_q <= bus_wdata;
        endcase
      end
      if (inj_we) begin
        status_q <= inj_status;
        if (!inj_over_only) begin
          addr_q <= inj_addr;
          misc_q <= inj_misc;
        end
      end
    end
  end
endmodule

// File: rtl/mcb_logger.sv
module mcb_logger
  import mcb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = $clog2(BANK_BASE + 4 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mce_en,
  input  logic [3:0]        ver_family,
  input  logic [3:0]        ver_model,
  input  logic [3:0]        ver_ext_model,
  input  logic              inj_valid,
  input  logic [7:0]        inj_bank,
  input  logic [63:0]       inj_status,
  input  logic [63:0]       inj_gstat,
  input  logic [63:0]       inj_addr,
  input  logic [63:0]       inj_misc,
  input  logic              inj_uncond,
  input  logic              inj_bcast,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              res_valid,
  output logic [1:0]        res_code,
  output logic              mc_irq,
  output logic              reset_req
);
  localparam int AB_W = ADDR_W - 2;
  localparam logic [AB_W-1:0] BANK_OFS = AB_W'(BANK_BASE / 4);
  localparam logic [WORD_W-1:0] CAP_RST =
    WORD_W'((64'd1 << CAP_GCTL) | 64'(NUM_BANKS));

  logic [WORD_W-1:0] cap_q, gstat_q, gctl_q;
  logic [WORD_W-1:0] b_ctl    [NUM_BANKS];
  logic [WORD_W-1:0] b_status [NUM_BANKS];
  logic [WORD_W-1:0] b_addr   [NUM_BANKS];
  logic [WORD_W-1:0] b_misc   [NUM_BANKS];

  inj_t              inj;
  logic              bcast_ok;
  logic [WORD_W-1:0] sel_ctl, sel_status;
  res_e              code;
  upd_e              upd;
  logic [WORD_W-1:0] new_status;
  logic              wr_gstat, irq, rreq;
  logic              in_bank_space;
  logic [AB_W-1:0]   bus_bank;
  logic [WORD_W-1:0] rd_mux;

  assign inj = '{bank: inj_bank, status: inj_status, gstat: inj_gstat,
                 addr: inj_addr, misc: inj_misc, uncond: inj_uncond,
                 bcast: inj_bcast};

  assign in_bank_space = reg_addr >= ADDR_W'(BANK_BASE);
  assign bus_bank      = reg_addr[ADDR_W-1:2] - BANK_OFS;

  mcb_bcast_check u_bcast (
    .family    (ver_family),
    .model     (ver_model),
    .ext_model (ver_ext_model),
    .ok        (bcast_ok)
  );

  always_comb begin
    sel_ctl    = '0;
    sel_status = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (inj_bank == 8'(i)) begin
        sel_ctl    = b_ctl[i];
        sel_status = b_status[i];
      end
    end
  end

  mcb_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .inj         (inj),
    .cap_banks   (cap_q[7:0]),
    .cap_zero    (cap_q == '0),
    .cap_gctl    (cap_q[CAP_GCTL]),
    .gs_mcip     (gstat_q[GS_MCIP]),
    .gctl        (gctl_q),
    .bank_ctl    (sel_ctl),
    .bank_status (sel_status),
    .mce_en      (mce_en),
    .bcast_ok    (bcast_ok),
    .code        (code),
    .upd         (upd),
    .new_status  (new_status),
    .wr_gstat    (wr_gstat),
    .irq         (irq),
    .rreq        (rreq)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    mcb_bank u_bank (
      .clk           (clk),
      .rst           (rst),
      .bus_we        (reg_wr && in_bank_space && (bus_bank == AB_W'(g))),
      .bus_field     (reg_addr[1:0]),
      .bus_wdata     (reg_wdata),
      .inj_we        (inj_valid && (inj_bank == 8'(g)) && (upd != UPD_NONE)),
      .inj_over_only (upd == UPD_OVER),
      .inj_status    (new_status),
      .inj_addr      (inj_addr),
      .inj_misc      (inj_misc),
      .ctl_q         (b_ctl[g]),
      .status_q      (b_status[g]),
      .addr_q        (b_addr[g]),
      .misc_q        (b_misc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= CAP_RST;
      gstat_q <= '0;
      gctl_q  <= '1;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          ADDR_W'(0): cap_q   <= reg_wdata;
          ADDR_W'(1): gstat_q <= reg_wdata;
          ADDR_W'(2): gctl_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (inj_valid && wr_gstat) gstat_q <= inj_gstat;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(0)) rd_mux = cap_q;
    else if (reg_addr == ADDR_W'(1)) rd_mux = gstat_q;
    else if (reg_addr == ADDR_W'(2)) rd_mux = gctl_q;
    else if (in_bank_space) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        if (bus_bank == AB_W'(i)) begin
          case (reg_addr[1:0])
            2'd0: rd_mux = b_ctl[i];
            2'd1: rd_mux = b_status[i];
            2'd2: rd_mux = b_addr[i];
            default: rd_mux = b_misc[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      res_valid <= 1'b0;
      res_code  <= 2'd0;
      mc_irq    <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      res_valid <= inj_valid;
      res_code  <= inj_valid ? code : 2'd0;
      mc_irq    <= inj_valid && irq;
      reset_req <= inj_valid && rreq;
    end
  end
endmodule

// File: rtl/mcb_logger_chk.sv
module mcb_logger_chk (
  input logic        clk,
  input logic        rst,
  input logic        inj_valid,
  input logic        reg_wr,
  input logic        res_valid,
  input logic [1:0]  res_code,
  input logic        mc_irq,
  input logic        reset_req,
  input logic [63:0] gstat_q
);
  // R11: a result follows every strobe
  p_result_follows_r11: assert property (@(posedge clk) disable iff (rst)
    inj_valid |=> res_valid);
  // R11: no result without a strobe
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
    !inj_valid |=> !res_valid);
  // R8: interrupt only with an accepted result
  p_irq_accept_r8: assert property (@(posedge clk) disable iff (rst)
    mc_irq |-> (res_valid && res_code == 2'd0));
  // R7: reset request carries the reset code
  p_reset_code_r7: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (res_valid && res_code == 2'd3));
  // R7: escalation writes no global status
  p_reset_keeps_gstat_r7: assert property (@(posedge clk) disable iff (rst)
    (reset_req && !$past(reg_wr)) |-> $stable(gstat_q));
  // R7: interrupt and reset never together
  p_irq_reset_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(mc_irq && reset_req));
endmodule

bind mcb_logger mcb_logger_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .inj_valid (inj_valid),
  .reg_wr    (reg_wr),
  .res_valid (res_valid),
  .res_code  (res_code),
  .mc_irq    (mc_irq),
  .reset_req (reset_req),
  .gstat_q   (gstat_q)
);

// File: tb/tb_mcb_logger.sv
module tb_mcb_logger;
  localparam int AW = 5;
  localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
  localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mce_en = 1'b1;
  logic [3:0] ver_family = 4'd6, ver_model = 4'd0, ver_ext_model = 4'd0;
  logic inj_valid = 1'b0;
  logic [7:0] inj_bank = '0;
  logic [63:0] inj_status = '0, inj_gstat = '0, inj_addr = '0, inj_misc = '0;
  logic inj_uncond = 1'b0, inj_bcast = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic res_valid, mc_irq, reset_req;
  logic [1:0] res_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0] code;
    logic       irq;
    logic       rr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  mcb_logger #(.NUM_BANKS(4)) dut (
    .clk(clk), .rst(rst), .mce_en(mce_en),
    .ver_family(ver_family), .ver_model(ver_model), .ver_ext_model(ver_ext_model),
    .inj_valid(inj_valid), .inj_bank(inj_bank), .inj_status(inj_status),
    .inj_gstat(inj_gstat), .inj_addr(inj_addr), .inj_misc(inj_misc),
    .inj_uncond(inj_uncond), .inj_bcast(inj_bcast),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .res_valid(res_valid), .res_code(res_code),
    .mc_irq(mc_irq), .reset_req(reset_req)
  );

  // monitor: pop expected result and compare
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result code=%0d expected none", res_code);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_code !== e.code || mc_irq !== e.irq || reset_req !== e.rr) begin
          fails++;
          $display("FAIL %s code/irq/rst=%0d/%0b/%0b expected %0d/%0b/%0b",
                   e.tag, res_code, mc_irq, reset_req, e.code, e.irq, e.rr);
        end
      end
    end
  end

  task automatic inject(input logic [7:0] bank, input logic [63:0] st,
                        input logic [63:0] gs, input logic [63:0] ad,
                        input logic [63:0] mi, input logic unc, input logic bc,
                        input logic [1:0] code, input logic irq, input logic rr,
                        input string tag);
    exp_t e;
    e.code = code; e.irq = irq; e.rr = rr; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = bank; inj_status = st; inj_gstat = gs;
    inj_addr = ad; inj_misc = mi; inj_uncond = unc; inj_bcast = bc;
    @(negedge clk);
    inj_valid = 1'b0; inj_uncond = 1'b0; inj_bcast = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 res_valid=%b expected 0 one cycle later", res_valid);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || mc_irq !== 1'b0 || reset_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs after reset %b%b%b expected 000", res_valid, mc_irq, reset_req);
    end
    rd_chk(0, 64'h104, "R1 capability");
    rd_chk(2, ONES, "R1 global control");
    rd_chk(8, ONES, "R1 bank0 control");
    rd_chk(9, 64'h0, "R1 bank0 status");
    rd_chk(1, 64'h0, "R1 global status");
    rd_chk(5, 64'h0, "R2 unmapped read");

    // R9 corrected into empty bank, then overwrite with overflow
    inject(0, VAL | 64'h11, 0, 64'hA0, 64'hC0, 0, 0, 2'd0, 0, 0, "R9 corrected first");
    rd_chk(9, VAL | 64'h11, "R9 bank0 status");
    rd_chk(10, 64'hA0, "R9 bank0 address");
    rd_chk(11, 64'hC0, "R9 bank0 misc");
    rd_chk(1, 64'h0, "R9 global status untouched");
    inject(0, VAL | 64'h22, 0, 64'hA1, 64'hC1, 0, 0, 2'd0, 0, 0, "R9 corrected overwrite");
    rd_chk(9, VAL | OVR | 64'h22, "R9 overflow on overwrite");
    rd_chk(10, 64'hA1, "R9 address replaced");

    // R8 uncorrected accept
    inject(1, VAL | UC | AR | 64'h33, 64'h5, 64'hB0, 64'hD0, 0, 0, 2'd0, 1, 0, "R8 uncorrected accept");
    rd_chk(13, VAL | UC | AR | 64'h33, "R8 bank1 status");
    rd_chk(14, 64'hB0, "R8 bank1 address");
    rd_chk(1, 64'h5, "R8 global status written");

    // R5 action-optional while in progress
    inject(2, VAL | 64'h44, 0, 64'hE0, 0, 0, 0, 2'd1, 0, 0, "R5 optional dropped");
    rd_chk(17, 64'h0, "R5 bank2 untouched");
    inject(2, VAL | 64'h44, 0, 64'hE0, 0, 1, 0, 2'd0, 0, 0, "R5 unconditional accepted");
    rd_chk(17, VAL | 64'h44, "R5 bank2 logged");

    // R7 nested uncorrected
    inject(3, VAL | UC | AR | 64'h55, 64'h1, 64'hF0, 0, 0, 0, 2'd3, 0, 1, "R7 nested reset");
    rd_chk(21, 64'h0, "R7 bank3 not written");
    rd_chk(1, 64'h5, "R7 global status kept");

    // R10 corrected onto valid uncorrected entry
    wr(1, 64'h0);
    inject(1, VAL | 64'h66, 0, 64'hC0C0, 0, 0, 0, 2'd1, 0, 0, "R10 overflow only");
    rd_chk(13, VAL | UC | AR | OVR | 64'h33, "R10 status overflow only");
    rd_chk(14, 64'hB0, "R10 address kept");

    // R7 machine-check disabled
    mce_en = 1'b0;
    inject(3, VAL | UC | AR, 64'h1, 0, 0, 0, 0, 2'd3, 0, 1, "R7 disabled reset");
    rd_chk(21, 64'h0, "R7 bank3 still empty");
    mce_en = 1'b1;

    // R6 bank control and global control
    wr(16, 64'h0);
    inject(2, VAL | UC | AR | 64'h77, 64'h1, 0, 0, 0, 0, 2'd1, 0, 0, "R6 bank control off");
    rd_chk(17, VAL | 64'h44, "R6 bank2 unchanged");
    wr(2, 64'h0);
    inject(3, VAL | UC | AR | 64'h88, 64'h1, 64'h12, 0, 0, 0, 2'd1, 0, 0, "R6 global control off");
    rd_chk(21, 64'h0, "R6 bank3 unchanged");
    wr(0, 64'h4);
    inject(3, VAL | UC | AR | 64'h88, 64'h1, 64'h12, 0, 0, 0, 2'd0, 1, 0, "R6 global control not advertised");
    rd_chk(21, VAL | UC | AR | 64'h88, "R6 bank3 logged");
    rd_chk(1, 64'h1, "R8 global status replaced");

    // R3 rejections
    inject(4, VAL | 64'h1, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R3 bank beyond capability");
    inject(0, 64'h99, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R3 status not valid");
    rd_chk(9, VAL | OVR | 64'h22, "R3 bank0 unchanged");
    wr(0, 64'h0);
    inject(0, VAL | 64'h99, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R3 capability zero");
    rd_chk(9, VAL | OVR | 64'h22, "R3 bank0 unchanged again");
    wr(0, 64'h108);
    inject(5, VAL | 64'h1, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R3 bank beyond storage");
    wr(0, 64'h104);

    // R4 broadcast gate
    ver_family = 4'd6; ver_model = 4'hD; ver_ext_model = 4'd0;
    inject(0, VAL | 64'h1, 0, 0, 0, 0, 1, 2'd2, 0, 0, "R4 model 13 refused");
    ver_model = 4'hE;
    inject(0, VAL | 64'h2, 0, 0, 0, 0, 1, 2'd0, 0, 0, "R4 model 14 allowed");
    ver_model = 4'h0; ver_ext_model = 4'd1;
    inject(0, VAL | 64'h3, 0, 0, 0, 0, 1, 2'd0, 0, 0, "R4 model 16 allowed");
    ver_family = 4'd7; ver_ext_model = 4'd0;
    inject(0, VAL | 64'h4, 0, 0, 0, 0, 1, 2'd0, 0, 0, "R4 family 7 allowed");
    ver_family = 4'd5; ver_model = 4'hF;
    inject(0, VAL | 64'h5, 0, 0, 0, 0, 1, 2'd2, 0, 0, "R4 family 5 refused");
    rd_chk(9, VAL | OVR | 64'h4, "R4 bank0 last accepted");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 %0d results missing expected 0", sb.size());
    end
    finish_run();
  end
endmodule